// File: doc/BRIEF.md
# Sound CPU I/O Register Page

This block sits between an 8-bit-data, 16-bit-address sound processor bus and the peripherals around it. It decodes the sixteen bytes at 0x00F0 to 0x00FF as an I/O page and passes every other access through to an external RAM that shares the bus address and write data. Inside the page it holds a control byte, an index/data window into a 128-entry DSP register file, four byte-wide mailbox ports to and from a host, write strobes for three timer period registers, and read ports for three 4-bit timer counters.

A single write to the control byte does several things at once. It sets the three timer enables, clears either or both halves of the host-to-CPU mailbox, and switches a 64-byte boot ROM overlay over the top of memory. While the overlay is on, reads from the top 64 bytes return ROM bytes. Writes there always reach the RAM underneath. The ROM image is a parameter and is loaded into the block's storage at reset.

All bus inputs are plain per-cycle strobes. `bus_rdata` is combinational from the address in the same cycle, so reads take no wait states. Register updates and side effects of a write take effect at the clock edge that ends the access cycle. There is no valid/ready handshake, because the processor bus never stalls.

Top module: `sio_page`

## Requirements
- R1: Every access outside the page 0x00F0–0x00FF passes to RAM: `ram_we` follows `bus_wr`, and reads return `ram_rdata`, except in the ROM overlay case of R5. Offsets 0xF8 and 0xF9 of the page also pass to RAM for reads and writes.
- R2: After reset the timer enables are all 0 and the ROM overlay is on.
- R3: A write to 0xF1 loads bits 2:0 into `tmr_en` (bit i enables timer i), visible from the next cycle.
- R4: A write to 0xF1 with bit 4 set zeroes host-to-CPU ports 0 and 1. With bit 5 set it zeroes ports 2 and 3. The clear wins over a host write to the same port in that cycle.
- R5: Bit 7 of a 0xF1 write sets the ROM overlay from the next cycle. While it is on, a read of 0xFFC0+k returns ROM byte k, where byte k is bits [8k+7:8k] of `ROM_INIT`. The default image has byte 62 = 0xC0, byte 63 = 0xFF and all others 0. While it is off, those reads return `ram_rdata`.
- R6: A write anywhere in 0xFFC0–0xFFFF asserts `ram_we`, whatever the overlay state.
- R7: A write to 0xF2 stores an 8-bit DSP index, which reads back at 0xF2. `dsp_idx` shows its low 7 bits, and a read of 0xF3 returns `dsp_rdata`.
- R8: A write to 0xF3 pulses `dsp_we`, with `dsp_wdata` equal to the written byte, only if the stored index is below 128. Otherwise no `dsp_we` is produced.
- R9: A write to 0xF0 has no effect: no `ram_we`, `dsp_we`, period strobe or counter clear, and `tmr_en` and the overlay do not change. Writes to the other page offsets (except 0xF8/0xF9) never assert `ram_we`. Offsets 0xF0, 0xF1 and 0xFA–0xFC read as 0x00.
- R10: A write to 0xFA+i pulses `tmr_period_we[i]` for that cycle, with `tmr_period` equal to the written byte.
- R11: A read of 0xFD+i returns {4'b0, counter i}, where counter i is `tmr_cnt[4i+3:4i]`, and pulses `tmr_cnt_clr[i]` in the same cycle. A write to 0xFD+i also pulses `tmr_cnt_clr[i]`.
- R12: A read of 0xF4+i returns the last byte the host wrote with `host_sel`=i. A CPU write to 0xF4+i sets `host_port[8i+7:8i]` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data, also RAM write data |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_rdata | output | 8 | Read data, combinational |
| ram_we | output | 1 | Write enable to external RAM |
| ram_rdata | input | 8 | RAM data at `bus_addr` |
| dsp_idx | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write pulse |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register contents at `dsp_idx` |
| tmr_en | output | 3 | Timer enables |
| tmr_period_we | output | 3 | Timer period load pulses |
| tmr_period | output | 8 | Timer period value |
| tmr_cnt | input | 12 | Timer counters, 4 bits each |
| tmr_cnt_clr | output | 3 | Timer counter clear pulses |
| host_wr | input | 1 | Host mailbox write |
| host_sel | input | 2 | Host mailbox port number |
| host_wdata | input | 8 | Host mailbox data |
| host_port | output | 32 | CPU-to-host mailbox bytes, port i at [8i+7:8i] |
| rom_overlay | output | 1 | Boot ROM overlay active |

## Verification
A wrong control byte shows one cycle after the write that set it, as a wrong `tmr_en`, a wrong `rom_overlay`, or top-of-memory reads coming from the wrong source. A missed or misrouted port clear shows on the next mailbox read. A wrong DSP index shows on `dsp_idx` and in the 0xF2 readback one cycle after it is written. A write that wrongly passes the index gate, or a wrong decode, shows in the same cycle as a stray `ram_we`, `dsp_we` or timer strobe. A wrong ROM image byte shows on the first read of that address.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam logic [3:0] OFF_TEST   = 4'h0;
  localparam logic [3:0] OFF_CTRL   = 4'h1;
  localparam logic [3:0] OFF_IDX    = 4'h2;
  localparam logic [3:0] OFF_DATA   = 4'h3;
  localparam logic [3:0] OFF_PORT   = 4'h4;
  localparam logic [3:0] OFF_SCR0   = 4'h8;
  localparam logic [3:0] OFF_SCR1   = 4'h9;
  localparam logic [3:0] OFF_PERIOD = 4'hA;
  localparam logic [3:0] OFF_COUNT  = 4'hD;

  localparam int CTRL_CLR_LO = 4;
  localparam int CTRL_CLR_HI = 5;
  localparam int CTRL_ROM    = 7;

  typedef struct packed {
    logic       page;
    logic       wr;
    logic       rd;
    logic [3:0] off;
  } page_acc_t;

endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl #(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [NUM_TIMERS-1:0] en_bits,
  input  logic [1:0]            clr_bits,
  input  logic                  rom_bit,
  output logic [NUM_TIMERS-1:0] tmr_en,
  output logic                  rom_on,
  output logic [1:0]            clr_pulse
);

  logic [NUM_TIMERS-1:0] en_q;
  logic                  rom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      rom_q <= 1'b1;
    end else if (we) begin
      en_q  <= en_bits;
      rom_q <= rom_bit;
    end
  end

  assign tmr_en    = en_q;
  assign rom_on    = rom_q;
  assign clr_pulse = we ? clr_bits : 2'b00;

  AST_CTRL_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tmr_en == $past(en_bits)));  // R3
  AST_CTRL_ROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rom_on == $past(rom_bit)));  // R5

endmodule

// File: rtl/sio_dsp_win.sv
module sio_dsp_win #(
  parameter int IDX_W    = 8,
  parameter int DSP_REGS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idx_we,
  input  logic                     dat_we,
  input  logic [7:0]               wdata,
  output logic [IDX_W-1:0]         idx_q,
  output logic [$clog2(DSP_REGS)-1:0] dsp_idx,
  output logic                     dsp_we,
  output logic [7:0]               dsp_wdata
);

  localparam int DSP_AW = $clog2(DSP_REGS);

  logic [IDX_W-1:0] idx_r;
  logic             in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_r <= '0;
    else if (idx_we) idx_r <= IDX_W'(wdata);
  end

  generate
    if (IDX_W > DSP_AW) begin : g_gate
      assign in_range = (idx_r[IDX_W-1:DSP_AW] == '0);
    end else begin : g_open
      assign in_range = 1'b1;
    end
  endgenerate

  assign idx_q     = idx_r;
  assign dsp_idx   = idx_r[DSP_AW-1:0];
  assign dsp_we    = dat_we && in_range;
  assign dsp_wdata = wdata;

  AST_DSP_IDX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (dsp_idx == $past(wdata[DSP_AW-1:0])));  // R7

endmodule

// File: rtl/sio_ports.sv
module sio_ports #(
  parameter int NUM_PORTS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS/2-1:0]       clr_pair,
  input  logic                         host_wr,
  input  logic [$clog2(NUM_PORTS)-1:0] host_sel,
  input  logic [7:0]                   host_wdata,
  input  logic [NUM_PORTS-1:0]         cpu_we,
  input  logic [7:0]                   cpu_wdata,
  output logic [NUM_PORTS*8-1:0]       to_cpu,
  output logic [NUM_PORTS*8-1:0]       to_host
);

  localparam int SEL_W = $clog2(NUM_PORTS);

  logic [7:0] to_cpu_q  [NUM_PORTS];
  logic [7:0] to_host_q [NUM_PORTS];

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          to_cpu_q[i]  <= '0;
          to_host_q[i] <= '0;
        end else begin
          if (clr_pair[i/2])
            to_cpu_q[i] <= '0;
          else if (host_wr && host_sel == SEL_W'(i))
            to_cpu_q[i] <= host_wdata;
          if (cpu_we[i])
            to_host_q[i] <= cpu_wdata;
        end
      end
      assign to_cpu[i*8 +: 8]  = to_cpu_q[i];
      assign to_host[i*8 +: 8] = to_host_q[i];
    end

    for (genvar p = 0; p < NUM_PORTS/2; p++) begin : g_pair_chk
      AST_PAIR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pair[p] |=> (to_cpu[(2*p)*8 +: 8] == 8'h00 && to_cpu[(2*p+1)*8 +: 8] == 8'h00));  // R4
    end
  endgenerate

endmodule

// File: rtl/sio_boot_rom.sv
module sio_boot_rom #(
  parameter int                   BYTES = 64,
  parameter logic [BYTES*8-1:0]   INIT  = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(BYTES)-1:0] addr,
  output logic [7:0]               data
);

  logic [7:0] img_q [BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < BYTES; k++) img_q[k] <= INIT[k*8 +: 8];
    end
  end

  assign data = img_q[addr];

endmodule

// File: rtl/sio_page.sv
module sio_page
  import sio_pkg::*;
#(
  parameter int                     AW         = 16,
  parameter logic [15:0]            IO_BASE    = 16'h00F0,
  parameter int                     NUM_TIMERS = 3,
  parameter int                     CNT_W      = 4,
  parameter int                     NUM_PORTS  = 4,
  parameter int                     DSP_REGS   = 128,
  parameter int                     ROM_BYTES  = 64,
  parameter logic [ROM_BYTES*8-1:0] ROM_INIT   = {16'hFFC0, {(ROM_BYTES*8-16){1'b0}}}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 bus_addr,
  input  logic [7:0]                    bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [7:0]                    bus_rdata,
  output logic                          ram_we,
  input  logic [7:0]                    ram_rdata,
  output logic [$clog2(DSP_REGS)-1:0]   dsp_idx,
  output logic                          dsp_we,
  output logic [7:0]                    dsp_wdata,
  input  logic [7:0]                    dsp_rdata,
  output logic [NUM_TIMERS-1:0]         tmr_en,
  output logic [NUM_TIMERS-1:0]         tmr_period_we,
  output logic [7:0]                    tmr_period,
  input  logic [NUM_TIMERS*CNT_W-1:0]   tmr_cnt,
  output logic [NUM_TIMERS-1:0]         tmr_cnt_clr,
  input  logic                          host_wr,
  input  logic [$clog2(NUM_PORTS)-1:0]  host_sel,
  input  logic [7:0]                    host_wdata,
  output logic [NUM_PORTS*8-1:0]        host_port,
  output logic                          rom_overlay
);

  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam int IDX_W  = 8;

  page_acc_t                acc;
  logic                     rom_hit;
  logic [1:0]               clr_pair;
  logic [IDX_W-1:0]         idx_full;
  logic [7:0]               rom_byte;
  logic [NUM_PORTS-1:0]     port_we;
  logic [NUM_PORTS*8-1:0]   to_cpu;
  logic                     scratch;

  // Address decode
  assign acc.page = (bus_addr[AW-1:4] == IO_BASE[AW-1:4]);
  assign acc.off  = bus_addr[3:0];
  assign acc.wr   = bus_wr && acc.page;
  assign acc.rd   = bus_rd && acc.page;
  assign rom_hit  = &bus_addr[AW-1:ROM_AW];
  assign scratch  = (acc.off == OFF_SCR0) || (acc.off == OFF_SCR1);

  // RAM write-through: everything outside the page, plus the scratch bytes
  assign ram_we = bus_wr && (!acc.page || scratch);

  sio_ctrl #(.NUM_TIMERS(NUM_TIMERS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (acc.wr && acc.off == OFF_CTRL),
    .en_bits   (bus_wdata[NUM_TIMERS-1:0]),
    .clr_bits  (bus_wdata[CTRL_CLR_HI:CTRL_CLR_LO]),
    .rom_bit   (bus_wdata[CTRL_ROM]),
    .tmr_en    (tmr_en),
    .rom_on    (rom_overlay),
    .clr_pulse (clr_pair)
  );

  sio_dsp_win #(.IDX_W(IDX_W), .DSP_REGS(DSP_REGS)) u_dsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (acc.wr && acc.off == OFF_IDX),
    .dat_we    (acc.wr && acc.off == OFF_DATA),
    .wdata     (bus_wdata),
    .idx_q     (idx_full),
    .dsp_idx   (dsp_idx),
    .dsp_we    (dsp_we),
    .dsp_wdata (dsp_wdata)
  );

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port_dec
      assign port_we[i] = acc.wr && (acc.off == 4'(OFF_PORT + i));
    end
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr_dec
      assign tmr_period_we[t] = acc.wr && (acc.off == 4'(OFF_PERIOD + t));
      assign tmr_cnt_clr[t]   = (acc.wr || acc.rd) && (acc.off == 4'(OFF_COUNT + t));
    end
  endgenerate

  assign tmr_period = bus_wdata;

  sio_ports #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_pair   (clr_pair[NUM_PORTS/2-1:0]),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .cpu_we     (port_we),
    .cpu_wdata  (bus_wdata),
    .to_cpu     (to_cpu),
    .to_host    (host_port)
  );

  sio_boot_rom #(.BYTES(ROM_BYTES), .INIT(ROM_INIT)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr[ROM_AW-1:0]),
    .data  (rom_byte)
  );

  // Read data mux
  always_comb begin
    bus_rdata = ram_rdata;
    if (rom_hit && rom_overlay) begin
      bus_rdata = rom_byte;
    end else if (acc.page) begin
      bus_rdata = 8'h00;
      if (acc.off == OFF_IDX)  bus_rdata = idx_full;
      if (acc.off == OFF_DATA) bus_rdata = dsp_rdata;
      if (scratch)             bus_rdata = ram_rdata;
      for (int i = 0; i < NUM_PORTS; i++)
        if (acc.off == 4'(OFF_PORT + i)) bus_rdata = to_cpu[i*8 +: 8];
      for (int t = 0; t < NUM_TIMERS; t++)
        if (acc.off == 4'(OFF_COUNT + t)) bus_rdata = 8'(tmr_cnt[t*CNT_W +: CNT_W]);
    end
  end

  AST_OUTSIDE_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !acc.page) |-> ram_we);  // R1
  AST_ROM_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && rom_hit) |-> ram_we);  // R6
  AST_TEST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && acc.off == OFF_TEST) |->
      (!ram_we && !dsp_we && tmr_period_we == '0 && tmr_cnt_clr == '0));  // R9
  AST_TEST_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && acc.off == OFF_TEST) |=> ($stable(tmr_en) && $stable(rom_overlay)));  // R9
  AST_PERIOD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_period_we));  // R10
  AST_COUNTER_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_cnt_clr));  // R11

endmodule

// File: tb/sio_page_tb.sv
`timescale 1ns/1ps
module sio_page_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        ram_we;
  logic [7:0]  ram_rdata;
  logic [6:0]  dsp_idx;
  logic        dsp_we;
  logic [7:0]  dsp_wdata;
  logic [7:0]  dsp_rdata;
  logic [2:0]  tmr_en;
  logic [2:0]  tmr_period_we;
  logic [7:0]  tmr_period;
  logic [11:0] tmr_cnt = 12'h39F;
  logic [2:0]  tmr_cnt_clr;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] host_port;
  logic        rom_overlay;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          kq[$];
  logic [31:0] eq[$];
  string       tq[$];

  always #2.5 clk = ~clk;

  // Bench models of RAM and DSP register file
  assign ram_rdata = bus_addr[7:0] ^ 8'h5A;
  assign dsp_rdata = {dsp_idx, 1'b1};

  sio_page u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .dsp_idx(dsp_idx), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
    .dsp_rdata(dsp_rdata), .tmr_en(tmr_en), .tmr_period_we(tmr_period_we),
    .tmr_period(tmr_period), .tmr_cnt(tmr_cnt), .tmr_cnt_clr(tmr_cnt_clr),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_port(host_port), .rom_overlay(rom_overlay)
  );

  // kinds: 0 rdata, 1 ram_we, 2 dsp full, 3 period, 4 cnt_clr, 5 tmr_en, 6 overlay, 7 host_port, 8 dsp_we
  task automatic expect_(input int kind, input logic [31:0] val, input string tag);
    kq.push_back(kind);
    eq.push_back(val);
    tq.push_back(tag);
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w, input logic r);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = w;
    bus_rd    = r;
    host_wr   = 1'b0;
  endtask

  task automatic idle();
    step(16'h0300, 8'h00, 1'b0, 1'b0);
  endtask

  // Monitor: compare queued expectations against the outputs mid-cycle
  always begin
    @(negedge clk);
    #1;
    while (kq.size() > 0) begin
      int          k;
      logic [31:0] e;
      logic [31:0] act;
      string       tg;
      k  = kq.pop_front();
      e  = eq.pop_front();
      tg = tq.pop_front();
      case (k)
        0: act = {24'h0, bus_rdata};
        1: act = {31'h0, ram_we};
        2: act = {16'h0, dsp_we, dsp_idx, dsp_wdata};
        3: act = {21'h0, tmr_period_we, tmr_period};
        4: act = {29'h0, tmr_cnt_clr};
        5: act = {29'h0, tmr_en};
        6: act = {31'h0, rom_overlay};
        7: act = host_port;
        default: act = {31'h0, dsp_we};
      endcase
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", tg, act, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    idle();
    expect_(5, 32'h0, "R2 timers off");
    expect_(6, 32'h1, "R2 overlay on");
    step(16'hFFFE, 8'h00, 1'b0, 1'b1); expect_(0, 32'hC0, "R5 rom byte 62");
    step(16'hFFFF, 8'h00, 1'b0, 1'b1); expect_(0, 32'hFF, "R5 rom byte 63");
    step(16'hFFC0, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R5 rom byte 0");

    // Plain RAM pass-through
    step(16'h1234, 8'h00, 1'b0, 1'b1); expect_(0, 32'h6E, "R1 ram read");
    step(16'h0010, 8'h33, 1'b1, 1'b0); expect_(1, 32'h1, "R1 ram write");
    step(16'h00EF, 8'h33, 1'b1, 1'b0); expect_(1, 32'h1, "R1 ram write below page");
    step(16'h00F8, 8'h00, 1'b0, 1'b1); expect_(0, 32'hA2, "R1 scratch read");
    step(16'h00F9, 8'h12, 1'b1, 1'b0); expect_(1, 32'h1, "R1 scratch write");

    // Writes under the overlay reach RAM
    step(16'hFFC1, 8'h44, 1'b1, 1'b0); expect_(1, 32'h1, "R6 write with overlay on");

    // Control: timers 0,2 on, overlay off
    step(16'h00F1, 8'h05, 1'b1, 1'b0); expect_(1, 32'h0, "R9 ctrl write not to ram");
    idle();
    expect_(5, 32'h5, "R3 timer enables");
    expect_(6, 32'h0, "R5 overlay off");
    step(16'hFFFE, 8'h00, 1'b0, 1'b1); expect_(0, 32'hA4, "R5 ram under rom");
    step(16'hFFC1, 8'h44, 1'b1, 1'b0); expect_(1, 32'h1, "R6 write with overlay off");
    step(16'h00F1, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R9 ctrl reads zero");

    // Test register is ignored
    step(16'h00F0, 8'hFF, 1'b1, 1'b0);
    expect_(1, 32'h0, "R9 test no ram_we");
    expect_(8, 32'h0, "R9 test no dsp_we");
    expect_(3, 32'h0FF, "R9 test no period strobe");
    expect_(4, 32'h0, "R9 test no counter clear");
    idle();
    expect_(5, 32'h5, "R9 test keeps enables");
    expect_(6, 32'h0, "R9 test keeps overlay");
    step(16'h00F0, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R9 test reads zero");

    step(16'h00F1, 8'h87, 1'b1, 1'b0);
    idle();
    expect_(5, 32'h7, "R3 all timers on");
    expect_(6, 32'h1, "R5 overlay back on");

    // Host mailbox
    for (int i = 0; i < 4; i++) begin
      idle();
      host_wr = 1'b1; host_sel = 2'(i); host_wdata = 8'(8'h11 * (i + 1));
    end
    step(16'h00F4, 8'h00, 1'b0, 1'b1); expect_(0, 32'h11, "R12 port0 read");
    step(16'h00F7, 8'h00, 1'b0, 1'b1); expect_(0, 32'h44, "R12 port3 read");

    // Low-pair clear racing a host write to port 1
    step(16'h00F1, 8'h97, 1'b1, 1'b0);
    host_wr = 1'b1; host_sel = 2'd1; host_wdata = 8'h55;
    step(16'h00F4, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R4 port0 cleared");
    step(16'h00F5, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R4 port1 clear beats host");
    step(16'h00F6, 8'h00, 1'b0, 1'b1); expect_(0, 32'h33, "R4 port2 kept");
    step(16'h00F7, 8'h00, 1'b0, 1'b1); expect_(0, 32'h44, "R4 port3 kept");
    step(16'h00F1, 8'hA7, 1'b1, 1'b0);
    step(16'h00F6, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R4 port2 cleared");
    step(16'h00F7, 8'h00, 1'b0, 1'b1); expect_(0, 32'h00, "R4 port3 cleared");

    // CPU to host
    step(16'h00F5, 8'h6B, 1'b1, 1'b0); expect_(1, 32'h0, "R9 port write not to ram");
    idle(); expect_(7, 32'h00006B00, "R12 host_port byte 1");

    // DSP window
    step(16'h00F2, 8'h8C, 1'b1, 1'b0);
    step(16'h00F2, 8'h00, 1'b0, 1'b1); expect_(0, 32'h8C, "R7 index readback");
    step(16'h00F3, 8'h00, 1'b0, 1'b1); expect_(0, 32'h19, "R7 data read via low bits");
    step(16'h00F3, 8'h77, 1'b1, 1'b0); expect_(8, 32'h0, "R8 index 0x8C dropped");
    step(16'h00F2, 8'h2A, 1'b1, 1'b0);
    step(16'h00F3, 8'h77, 1'b1, 1'b0); expect_(2, {16'h0, 1'b1, 7'h2A, 8'h77}, "R8 write 0x2A");
    step(16'h00F2, 8'h7F, 1'b1, 1'b0);
    step(16'h00F3, 8'h01, 1'b1, 1'b0); expect_(2, {16'h0, 1'b1, 7'h7F, 8'h01}, "R8 index 127 passes");
    step(16'h00F2, 8'h80, 1'b1, 1'b0);
    step(16'h00F3, 8'h01, 1'b1, 1'b0); expect_(8, 32'h0, "R8 index 128 dropped");

    // Timer periods
    step(16'h00FB, 8'h40, 1'b1, 1'b0); expect_(3, {21'h0, 3'b010, 8'h40}, "R10 period 1");
    step(16'h00FA, 8'h00, 1'b1, 1'b0); expect_(3, {21'h0, 3'b001, 8'h00}, "R10 period 0");
    step(16'h00FC, 8'h00, 1'b0, 1'b1);
    expect_(0, 32'h00, "R9 period reads zero");
    expect_(3, 32'h0, "R10 no strobe on read");

    // Timer counters
    step(16'h00FE, 8'h00, 1'b0, 1'b1);
    expect_(0, 32'h09, "R11 counter 1 value");
    expect_(4, 32'h2, "R11 counter 1 clear");
    step(16'h00FD, 8'h00, 1'b0, 1'b1);
    expect_(0, 32'h0F, "R11 counter 0 value");
    expect_(4, 32'h1, "R11 counter 0 clear");
    step(16'h00FF, 8'h00, 1'b1, 1'b0);
    expect_(4, 32'h4, "R11 counter 2 clear on write");
    expect_(1, 32'h0, "R9 counter write not to ram");
    idle(); expect_(4, 32'h0, "R11 no clear when idle");

    idle();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule